// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block turns a (process ID, virtual page number) pair into a physical address by searching a table that holds exactly one entry per physical frame. Each entry records whether it is in use, which process owns it and which virtual page that process has placed there. Because the table is indexed by frame, the frame number never needs to be stored: it is simply the position at which the matching entry is found.

A lookup starts at a home slot derived by folding the process ID and page number together with XOR. The search then steps through consecutive slots, one per clock, wrapping at the end of the table, until an entry matches or a fixed number of slots has been examined. A hit returns the frame index joined to the untranslated page offset; a miss is reported so that a fault handler elsewhere can take over. A separate write port lets software set or clear any slot; a request is not accepted in a cycle in which that port is writing.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `resp_valid` and `resp_hit` are 0 and `lookup_ready` is 1 while `wr_en` is low.
- R2: The home slot is the XOR fold of the process ID and the page number onto the 6-bit slot index: bit b of either operand is XORed into slot bit (b mod 6); with the defaults this is pid[5:0]^pid[7:6]^vpn[5:0]^vpn[11:6]^vpn[17:12]^vpn[18].
- R3: A slot matches only when its valid flag is 1 and its stored process ID and page number both equal the request's; a slot differing in either field, or with the flag 0, is passed over.
- R4: On a hit `resp_paddr` is {slot index (6 bits), page offset (13 bits)}; on a miss `resp_hit` is 0 and `resp_paddr` is 0.
- R5: Probing visits home, home+1, home+2, ... modulo 64, one slot per cycle, so a match found at probe k (counting from 0) is reported with `resp_valid` high k+1 cycles after the accepting edge.
- R6: At most PROBE_LIMIT slots (default 8) are examined; an entry at distance PROBE_LIMIT or more from home is not found, and a miss is reported PROBE_LIMIT cycles after acceptance.
- R7: `resp_valid` is a one-cycle pulse per accepted request.
- R8: While `wr_en` is high `lookup_ready` is 0, no request is accepted and no response is produced from it.
- R9: A write with `wr_en` high stores {wr_valid, wr_pid, wr_vpn} into slot `wr_frame`; writing `wr_valid`=0 removes a previously findable mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Request present |
| lookup_pid | input | PID_W | Requesting process ID |
| lookup_vpn | input | VPN_W | Virtual page number |
| lookup_off | input | OFF_W | Page offset, passed through |
| lookup_ready | output | 1 | Request accepted this cycle if valid |
| wr_en | input | 1 | Table write strobe |
| wr_frame | input | log2(FRAMES) | Slot written |
| wr_valid | input | 1 | Valid flag stored |
| wr_pid | input | PID_W | Owner process ID stored |
| wr_vpn | input | VPN_W | Page number stored |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | 1 on match, 0 on miss |
| resp_paddr | output | log2(FRAMES)+OFF_W | Physical address |

## Verification
The bench builds the block with its defaults: 64 frames, an 8-bit process ID, a 19-bit page number, a 13-bit offset and a probe limit of 8. With a table that small, keys can be crafted to land on any chosen home slot, so chains of colliding entries, a chain that wraps past slot 63 into slot 0, and entries exactly at probe 7 and probe 8 are all reachable. A limit of 8 against 64 slots keeps the hit and miss latencies short and distinct, so each probe position is told apart by the cycle on which the response arrives.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } probe_state_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W = 8,
  parameter int VPN_W = 19,
  parameter int IDX_W = 6
) (
  input  logic [PID_W-1:0] pid,
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx
);
  // Fold every operand bit onto slot bit (position mod IDX_W).
  always_comb begin
    idx = '0;
    for (int b = 0; b < PID_W; b++) idx[b % IDX_W] = idx[b % IDX_W] ^ pid[b];
    for (int b = 0; b < VPN_W; b++) idx[b % IDX_W] = idx[b % IDX_W] ^ vpn[b];
  end
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int PID_W = 8,
  parameter int VPN_W = 19,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PID_W-1:0] rd_pid,
  output logic [VPN_W-1:0] rd_vpn
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = 1 + PID_W + VPN_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_valid, wr_pid, wr_vpn};
    rd_q <= mem[rd_idx];
  end

  assign {rd_valid, rd_pid, rd_vpn} = rd_q;
endmodule

// File: rtl/ipt_probe_fsm.sv
module ipt_probe_fsm
  import ipt_pkg::*;
#(
  parameter int PID_W       = 8,
  parameter int VPN_W       = 19,
  parameter int OFF_W       = 13,
  parameter int IDX_W       = 6,
  parameter int PROBE_LIMIT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [PID_W-1:0]       req_pid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  input  logic [IDX_W-1:0]       home_idx,
  input  logic                   wr_busy,
  output logic                   req_ready,
  output logic [IDX_W-1:0]       rd_idx,
  input  logic                   ent_valid,
  input  logic [PID_W-1:0]       ent_pid,
  input  logic [VPN_W-1:0]       ent_vpn,
  output logic                   resp_valid,
  output logic                   resp_hit,
  output logic [IDX_W+OFF_W-1:0] resp_paddr
);
  localparam int CNT_W = $clog2(PROBE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROBE_LIMIT - 1);

  probe_state_e     state;
  logic [PID_W-1:0] key_pid;
  logic [VPN_W-1:0] key_vpn;
  logic [OFF_W-1:0] key_off;
  logic [IDX_W-1:0] chk_idx;
  logic [IDX_W-1:0] home_q;
  logic [CNT_W-1:0] cnt;
  logic             match;
  logic             last;

  assign match     = ent_valid && (ent_pid == key_pid) && (ent_vpn == key_vpn);
  assign last      = (cnt == LAST_CNT);
  assign req_ready = (state == ST_IDLE) && !wr_busy;
  // Read address runs one slot ahead of the slot being compared.
  assign rd_idx    = (state == ST_IDLE) ? home_idx : chk_idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_paddr <= '0;
      key_pid    <= '0;
      key_vpn    <= '0;
      key_off    <= '0;
      chk_idx    <= '0;
      home_q     <= '0;
      cnt        <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            key_pid <= req_pid;
            key_vpn <= req_vpn;
            key_off <= req_off;
            chk_idx <= home_idx;
            home_q  <= home_idx;
            cnt     <= '0;
            state   <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (match) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_paddr <= {chk_idx, key_off};
            state      <= ST_IDLE;
          end else if (last) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_paddr <= '0;
            state      <= ST_IDLE;
          end else begin
            chk_idx <= chk_idx + IDX_W'(1);
            cnt     <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [IDX_W-1:0] hit_dist;
  assign hit_dist = resp_paddr[IDX_W+OFF_W-1:OFF_W] - home_q;

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  assert_write_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && wr_busy) |=> (state == ST_IDLE && !resp_valid));

  assert_probe_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH) |-> (cnt <= LAST_CNT));

  assert_hit_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (int'(hit_dist) < PROBE_LIMIT));

  assert_miss_at_limit_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH && !match && last) |=> (resp_valid && !resp_hit));

  assert_miss_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (resp_paddr == '0));
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int PID_W       = 8,
  parameter int VPN_W       = 19,
  parameter int OFF_W       = 13,
  parameter int FRAMES      = 64,
  parameter int PROBE_LIMIT = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           lookup_valid,
  input  logic [PID_W-1:0]               lookup_pid,
  input  logic [VPN_W-1:0]               lookup_vpn,
  input  logic [OFF_W-1:0]               lookup_off,
  output logic                           lookup_ready,
  input  logic                           wr_en,
  input  logic [$clog2(FRAMES)-1:0]      wr_frame,
  input  logic                           wr_valid,
  input  logic [PID_W-1:0]               wr_pid,
  input  logic [VPN_W-1:0]               wr_vpn,
  output logic                           resp_valid,
  output logic                           resp_hit,
  output logic [$clog2(FRAMES)+OFF_W-1:0] resp_paddr
);
  localparam int IDX_W = $clog2(FRAMES);

  logic [IDX_W-1:0] home_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             ent_valid;
  logic [PID_W-1:0] ent_pid;
  logic [VPN_W-1:0] ent_vpn;

  ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .pid (lookup_pid),
    .vpn (lookup_vpn),
    .idx (home_idx)
  );

  ipt_table #(.PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_idx   (wr_frame),
    .wr_valid (wr_valid),
    .wr_pid   (wr_pid),
    .wr_vpn   (wr_vpn),
    .rd_idx   (rd_idx),
    .rd_valid (ent_valid),
    .rd_pid   (ent_pid),
    .rd_vpn   (ent_vpn)
  );

  ipt_probe_fsm #(
    .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .PROBE_LIMIT(PROBE_LIMIT)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (lookup_valid),
    .req_pid    (lookup_pid),
    .req_vpn    (lookup_vpn),
    .req_off    (lookup_off),
    .home_idx   (home_idx),
    .wr_busy    (wr_en),
    .req_ready  (lookup_ready),
    .rd_idx     (rd_idx),
    .ent_valid  (ent_valid),
    .ent_pid    (ent_pid),
    .ent_vpn    (ent_vpn),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_paddr (resp_paddr)
  );
endmodule

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_valid = 1'b0;
  logic [7:0]  lookup_pid = '0;
  logic [18:0] lookup_vpn = '0;
  logic [12:0] lookup_off = '0;
  logic        lookup_ready;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_frame = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_pid = '0;
  logic [18:0] wr_vpn = '0;
  logic        resp_valid;
  logic        resp_hit;
  logic [18:0] resp_paddr;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipt_lookup u_dut (
    .clk(clk), .rst(rst),
    .lookup_valid(lookup_valid), .lookup_pid(lookup_pid), .lookup_vpn(lookup_vpn),
    .lookup_off(lookup_off), .lookup_ready(lookup_ready),
    .wr_en(wr_en), .wr_frame(wr_frame), .wr_valid(wr_valid),
    .wr_pid(wr_pid), .wr_vpn(wr_vpn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_paddr(resp_paddr)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] home_of(input logic [7:0] p, input logic [18:0] v);
    return p[5:0] ^ {4'b0, p[7:6]} ^ v[5:0] ^ v[11:6] ^ v[17:12] ^ {5'b0, v[18]};
  endfunction

  function automatic logic [18:0] vpn_for(input logic [7:0] p, input logic [12:0] hi,
                                          input logic [5:0] target);
    logic [18:0] v;
    v = {hi, 6'b0};
    v[5:0] = target ^ home_of(p, v);
    return v;
  endfunction

  task automatic put(input logic [5:0] f, input logic v, input logic [7:0] p,
                     input logic [18:0] vp);
    @(negedge clk);
    wr_en = 1'b1; wr_frame = f; wr_valid = v; wr_pid = p; wr_vpn = vp;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue one request and check hit flag, address and latency in cycles.
  task automatic lookup(input logic [7:0] p, input logic [18:0] vp, input logic [12:0] off,
                        input logic exp_hit, input logic [5:0] exp_frame, input int exp_lat,
                        input string tag);
    int n;
    logic [18:0] exp_pa;
    @(negedge clk);
    while (!lookup_ready) @(negedge clk);
    lookup_valid = 1'b1; lookup_pid = p; lookup_vpn = vp; lookup_off = off;
    @(posedge clk); #1;
    lookup_valid = 1'b0;
    n = 0;
    for (int i = 0; i < 2*LIMIT + 4; i++) begin
      @(posedge clk); #1;
      n++;
      if (resp_valid) break;
    end
    exp_pa = exp_hit ? {exp_frame, off} : 19'd0;
    check(resp_valid == 1'b1, {tag, " resp_valid"}, int'(resp_valid), 1);
    check(n == exp_lat, {tag, " latency"}, n, exp_lat);
    check(resp_hit == exp_hit, {tag, " hit"}, int'(resp_hit), int'(exp_hit));
    check(resp_paddr == exp_pa, {tag, " paddr"}, int'(resp_paddr), int'(exp_pa));
    @(posedge clk); #1;
    check(resp_valid == 1'b0, {tag, " R7 pulse"}, int'(resp_valid), 0);
  endtask

  task automatic t_reset();
    #1;
    check(resp_valid == 1'b0, "R1 resp_valid at reset", int'(resp_valid), 0);
    check(resp_hit == 1'b0, "R1 resp_hit at reset", int'(resp_hit), 0);
    check(lookup_ready == 1'b1, "R1 ready at reset", int'(lookup_ready), 1);
  endtask

  task automatic t_home_hit();
    logic [18:0] v;
    v = vpn_for(8'h11, 13'h0A5, 6'd5);
    put(6'd5, 1'b1, 8'h11, v);
    lookup(8'h11, v, 13'h1ABC, 1'b1, 6'd5, 1, "R2 R4 home hit");
  endtask

  task automatic t_collision();
    logic [18:0] v1, v2;
    v1 = vpn_for(8'h22, 13'h100, 6'd20);
    v2 = vpn_for(8'h22, 13'h101, 6'd20);
    put(6'd20, 1'b1, 8'h22, v1);
    put(6'd21, 1'b1, 8'h22, v2);
    lookup(8'h22, v2, 13'h0007, 1'b1, 6'd21, 2, "R5 second in chain");
    lookup(8'h22, v1, 13'h1FFF, 1'b1, 6'd20, 1, "R5 first in chain");
  endtask

  task automatic t_wrap();
    logic [18:0] v;
    v = vpn_for(8'h33, 13'h055, 6'd62);
    put(6'd0, 1'b1, 8'h33, v);
    lookup(8'h33, v, 13'h0123, 1'b1, 6'd0, 3, "R5 wrap to slot 0");
  endtask

  task automatic t_mismatch();
    logic [18:0] v;
    v = vpn_for(8'h44, 13'h0F0, 6'd40);
    put(6'd40, 1'b1, 8'h44, v);
    lookup(8'h44, v, 13'h0456, 1'b1, 6'd40, 1, "R3 exact key hits");
    // pid 0x05 folds to the same home as 0x44 but differs: must miss.
    lookup(8'h05, v, 13'h0456, 1'b0, 6'd0, LIMIT, "R3 pid mismatch");
    // vpn with bits 0 and 6 flipped keeps the home slot but differs.
    lookup(8'h44, v ^ 19'h41, 13'h0456, 1'b0, 6'd0, LIMIT, "R3 vpn mismatch");
    put(6'd40, 1'b0, 8'h44, v);
    lookup(8'h44, v, 13'h0456, 1'b0, 6'd0, LIMIT, "R9 R3 cleared entry");
  endtask

  task automatic t_limit();
    logic [18:0] v7, v8;
    v7 = vpn_for(8'h55, 13'h200, 6'd48);
    v8 = vpn_for(8'h55, 13'h201, 6'd48);
    put(6'd55, 1'b1, 8'h55, v7);
    put(6'd56, 1'b1, 8'h55, v8);
    lookup(8'h55, v7, 13'h0999, 1'b1, 6'd55, LIMIT, "R6 last probe hits");
    lookup(8'h55, v8, 13'h0999, 1'b0, 6'd0, LIMIT, "R6 beyond limit misses");
  endtask

  task automatic t_stall();
    logic [18:0] v;
    v = vpn_for(8'h66, 13'h321, 6'd10);
    put(6'd10, 1'b1, 8'h66, v);
    @(negedge clk);
    wr_en = 1'b1; wr_frame = 6'd30; wr_valid = 1'b0; wr_pid = '0; wr_vpn = '0;
    lookup_valid = 1'b1; lookup_pid = 8'h66; lookup_vpn = v; lookup_off = 13'h0042;
    for (int i = 0; i < 4; i++) begin
      #1;
      check(lookup_ready == 1'b0, "R8 ready low while writing", int'(lookup_ready), 0);
      @(posedge clk); #1;
      check(resp_valid == 1'b0, "R8 no response while writing", int'(resp_valid), 0);
      @(negedge clk);
    end
    wr_en = 1'b0; lookup_valid = 1'b0;
    repeat (LIMIT + 2) begin
      @(posedge clk); #1;
      check(resp_valid == 1'b0, "R8 stalled request never accepted", int'(resp_valid), 0);
    end
    lookup(8'h66, v, 13'h0042, 1'b1, 6'd10, 1, "R8 lookup after write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) put(i[5:0], 1'b0, 8'h00, 19'd0);
    t_home_hit();
    t_collision();
    t_wrap();
    t_mismatch();
    t_limit();
    t_stall();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule